// File: doc/BRIEF.md
# Level-Sensitive Interrupt Collector with Set/Clear Enable Registers

This block gathers up to 32 peripheral interrupt request lines and reduces them to two processor-facing interrupt outputs. Each request is brought into the clock domain through a short flop chain. It is then masked by its own enable bit and routed to one of two output groups by a per-source type bit.

Software controls the block over a simple 32-bit register bus. Enable bits are turned on by writing ones to a set address and turned off by writing ones to a separate clear address. A driver therefore never needs a read-modify-write to change one source. Bit 31 of the enable word also acts as a master gate for both outputs.

Requests are level sensitive. A source stays pending until the peripheral drops its line or software masks it. There is no separate acknowledge step.

Top module: `irq_collector`

## Requirements
- R1: After reset the enable word, the type word and the read data are all 0, and both `irq_grp0` and `irq_grp1` are low.
- R2: A write to byte offset 0x34 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to byte offset 0x38 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read of offset 0x34 returns the current enable word, bit 31 included.
- R5: A read of offset 0x30 returns the request levels after the synchronizer. With SYNC=2, a level applied before clock edge n is first returned by a read that is captured at edge n+2.
- R6: A read of offset 0x00 returns raw & enable & ~type (group 0 pending). A read of offset 0x04 returns raw & enable & type (group 1 pending). Neither depends on bit 31 beyond source 31's own enable.
- R7: Offset 0x20 is the read/write type word. Type bit k = 0 routes source k to group 0, and 1 routes it to group 1.
- R8: `irq_grp0` is high exactly when enable bit 31 is 1 and any group 0 pending bit is 1. `irq_grp1` follows the same rule for group 1.
- R9: While enable bit 31 is 0, both outputs stay low whatever the requests and other enables are.
- R10: Reads of any offset other than 0x00, 0x04, 0x20, 0x30 and 0x34 return 0. Writes to any offset other than 0x20, 0x34 and 0x38 change no state.
- R11: Read data is registered. It is valid in the cycle after `bus_rd` is high and is 0 in any cycle that follows a cycle with `bus_rd` low.
- R12: A request that is dropped by its peripheral, or whose enable is cleared, stops contributing to pending status and to the outputs. No other acknowledge exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Level-sensitive peripheral requests |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_grp0 | output | 1 | Combined interrupt of group 0 |
| irq_grp1 | output | 1 | Combined interrupt of group 1 |

## Verification
The bench builds the block with its defaults: NSRC=32, SYNC=2 and AW=8. At that size every source, including source 31 whose enable bit doubles as the master gate, can be swept one at a time. Each source is walked through set, clear and both group routings, and it is checked on both outputs and in every status register. The two-stage synchronizer is short enough to probe its latency with back-to-back reads. The 8-bit address space is small enough to try writes at every undefined word offset.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NSRC = 32,
  parameter int SYNC = 2,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_rd,
  output logic [31:0]     bus_rdata,
  output logic            irq_grp0,
  output logic            irq_grp1
);
  localparam int DW   = 32;
  localparam int GBIT = DW - 1;
  localparam logic [DW-1:0] SRC_MASK = (NSRC >= DW) ? '1 : ((DW'(1) << NSRC) - DW'(1));
  localparam logic [DW-1:0] EN_MASK  = SRC_MASK | (DW'(1) << GBIT);
  localparam logic [AW-1:0] A_PEND0 = AW'(8'h00);
  localparam logic [AW-1:0] A_PEND1 = AW'(8'h04);
  localparam logic [AW-1:0] A_TYPE  = AW'(8'h20);
  localparam logic [AW-1:0] A_RAW   = AW'(8'h30);
  localparam logic [AW-1:0] A_SET   = AW'(8'h34);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h38);

  // SYNC must be at least 2
  logic [SYNC-1:0][NSRC-1:0] sync_q;
  logic [DW-1:0] en_q, typ_q, raw_w, pend0, pend1;
  logic          wr_set, wr_clr, wr_typ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], irq_req};

  assign raw_w  = DW'(sync_q[SYNC-1]);
  assign wr_set = bus_wr && (bus_addr == A_SET);
  assign wr_clr = bus_wr && (bus_addr == A_CLR);
  assign wr_typ = bus_wr && (bus_addr == A_TYPE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      typ_q <= '0;
    end else begin
      en_q <= (en_q | (wr_set ? bus_wdata : '0)) & ~(wr_clr ? bus_wdata : '0) & EN_MASK;
      if (wr_typ) typ_q <= bus_wdata & SRC_MASK;
    end

  assign pend0 = raw_w & en_q & SRC_MASK & ~typ_q;
  assign pend1 = raw_w & en_q & typ_q;

  assign irq_grp0 = en_q[GBIT] & (|pend0);
  assign irq_grp1 = en_q[GBIT] & (|pend1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd)
      case (bus_addr)
        A_PEND0: bus_rdata <= pend0;
        A_PEND1: bus_rdata <= pend1;
        A_TYPE:  bus_rdata <= typ_q;
        A_RAW:   bus_rdata <= raw_w;
        A_SET:   bus_rdata <= en_q;
        default: bus_rdata <= '0;
      endcase
    else bus_rdata <= '0;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata & EN_MASK)) == $past(bus_wdata & EN_MASK))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(bus_wdata)) == '0)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(en_q)); // R10
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[GBIT] |-> !(irq_grp0 || irq_grp1)); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0)); // R11
  AST_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_grp0 || irq_grp1) |-> (|sync_q[SYNC-1])); // R12
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_req = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;
  logic        irq_grp0, irq_grp1;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_en = '0, m_typ = '0, m_req = '0;

  irq_collector #(.NSRC(32), .SYNC(2), .AW(8)) u_irq_collector (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_grp0(irq_grp0), .irq_grp1(irq_grp1));

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 0;
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk);
    irq_req = v; m_req = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d, p0, p1;
    p0 = m_req & m_en & ~m_typ;
    p1 = m_req & m_en & m_typ;
    rd(8'h00, d); chk({tag, " R6 pend0"}, d, p0);
    rd(8'h04, d); chk({tag, " R6 pend1"}, d, p1);
    rd(8'h30, d); chk({tag, " R5 raw"}, d, m_req);
    rd(8'h34, d); chk({tag, " R4 enable"}, d, m_en);
    rd(8'h20, d); chk({tag, " R7 type"}, d, m_typ);
    chk({tag, " R8 grp0"}, 32'(irq_grp0), 32'(m_en[31] & |p0));
    chk({tag, " R8 grp1"}, 32'(irq_grp1), 32'(m_en[31] & |p1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 grp0", 32'(irq_grp0), 0);
    chk("R1 grp1", 32'(irq_grp1), 0);
    check_all("R1");

    // R5 synchronizer latency with back-to-back reads
    @(negedge clk);
    irq_req = 32'hA5A5_0F0F; m_req = irq_req;
    bus_addr = 8'h30; bus_rd = 1;
    @(negedge clk); chk("R5 first edge", bus_rdata, 0);
    @(negedge clk); chk("R5 second edge", bus_rdata, 0);
    @(negedge clk); chk("R5 third edge", bus_rdata, 32'hA5A5_0F0F);
    bus_rd = 0;
    @(negedge clk); chk("R11 idle rdata", bus_rdata, 0);

    // R2 set sweep, one source at a time
    for (int k = 0; k < 32; k++) begin
      wr(8'h34, 32'(1) << k);
      m_en |= 32'(1) << k;
      rd(8'h34, d); chk("R2 set sweep", d, m_en);
    end
    wr(8'h34, 0); rd(8'h34, d); chk("R2 zero write", d, m_en);
    check_all("R2");

    // R7 type patterns
    wr(8'h20, 32'hFFFF_0000); m_typ = 32'hFFFF_0000; check_all("R7 a");
    wr(8'h20, 32'h0F0F_F0F0); m_typ = 32'h0F0F_F0F0; check_all("R7 b");

    // R3 clear
    wr(8'h38, 32'h0000_FFFF); m_en &= ~32'h0000_FFFF; check_all("R3 lo");
    wr(8'h38, 0); check_all("R3 zero write");

    // R9 global off
    wr(8'h34, 32'hFFFF_FFFF); m_en = '1;
    drive(32'hFFFF_FFFF);
    wr(8'h38, 32'h8000_0000); m_en[31] = 0;
    check_all("R9");
    chk("R9 grp0 low", 32'(irq_grp0), 0);
    chk("R9 grp1 low", 32'(irq_grp1), 0);
    wr(8'h34, 32'h8000_0000); m_en[31] = 1;
    check_all("R9 restore");

    // R10 undefined offsets and read-only registers
    for (int a = 0; a < 64; a++) begin
      logic [7:0] ad;
      ad = 8'(a * 4);
      if (ad == 8'h20 || ad == 8'h34 || ad == 8'h38) continue;
      wr(ad, 32'hFFFF_FFFF);
      wr(ad, 32'h0);
      if (ad != 8'h00 && ad != 8'h04 && ad != 8'h30) begin
        rd(ad, d); chk("R10 undefined read", d, 0);
      end
    end
    check_all("R10 state kept");

    // R12 level behaviour: peripheral drop, then masking
    drive(32'h0000_00F0);
    check_all("R12 partial");
    wr(8'h38, 32'h0000_00F0); m_en &= ~32'h0000_00F0;
    check_all("R12 masked");
    wr(8'h34, 32'h0000_00F0); m_en |= 32'h0000_00F0;
    drive(32'h0);
    check_all("R12 dropped");

    // R8 per-source sweep: one request, one enable plus global, both routings
    for (int k = 0; k < 32; k++) begin
      for (int g = 0; g < 2; g++) begin
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h34, (32'(1) << k) | 32'h8000_0000);
        m_en = (32'(1) << k) | 32'h8000_0000;
        m_typ = g ? (32'(1) << k) : 32'h0;
        wr(8'h20, m_typ);
        drive(32'(1) << k);
        chk("R8 sweep grp0", 32'(irq_grp0), 32'(g == 0));
        chk("R8 sweep grp1", 32'(irq_grp1), 32'(g == 1));
        rd(g ? 8'h04 : 8'h00, d); chk("R6 sweep pend", d, 32'(1) << k);
        drive(32'h0);
        chk("R12 sweep release", 32'(irq_grp0 | irq_grp1), 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule